// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle processor datapath. It is a Moore state machine with ten states held in a 4-bit register. In every cycle it drives a 16-bit set of datapath controls that depends only on the current state. The 6-bit opcode from the instruction register is consulted in only two states, where it chooses the next state. The controls select the memory address source, write enables, the ALU operand sources, the ALU mode and the program counter source.

An instruction begins in the fetch state. Decode follows, and then a short class-specific path that ends with a return to fetch. Five instruction classes are supported: load, store, register-type arithmetic, branch-on-equal and jump. An opcode that matches none of them sends the machine back to fetch. The opcode is a plain level input and carries no handshake. The datapath supplies it one cycle after fetch, and it must hold its value through the decode and address states.

Top module: `ctl_mc_fsm`

## Requirements
- R1: A high `rst` at a rising clock edge puts the state to 0 (fetch) at that edge. The state is visible on `state_o`.
- R2: With no other rule applying, the state advances by one: 0 goes to 1, 3 to 4, and 6 to 7.
- R3: From state 1, opcode 000000 (register-type) goes to 6, 100011 (load) and 101011 (store) go to 2, 000100 (branch-equal) goes to 8, and 000010 (jump) goes to 9.
- R4: From state 2, load goes to 3 and store goes to 5. Any other opcode goes to 0.
- R5: States 4, 5, 7, 8 and 9 always go to 0, whatever the opcode is.
- R6: From state 1, an opcode outside the five encodings of R3 goes to 0.
- R7: The controls depend on the state only. A change of `opcode` within a cycle leaves every control output unchanged.
- R8: In state 0, `mem_read`, `ir_load` and `pc_load` are 1, with `alu_b_sel`=01 (constant 4), `alu_op`=00 (add) and `pc_src`=00 (live ALU result). All other controls are 0.
- R9: In state 1, `alu_b_sel`=11 (extended offset shifted left by 2), and in state 2, `alu_a_reg`=1 with `alu_b_sel`=10 (extended offset). Both states use `alu_op`=00, and all other controls are 0.
- R10: State 3 asserts `mem_read` and `addr_from_alu`, and state 5 asserts `mem_write` and `addr_from_alu`. No other control is 1 in these states.
- R11: State 4 asserts `rf_write` and `rf_from_mem`, and state 7 asserts `rf_write` and `rf_dst_rd`. No other control is 1 in these states.
- R12: In state 6, `alu_a_reg`=1, `alu_b_sel`=00 (register B) and `alu_op`=10 (function field). In state 8, `alu_a_reg`=1, `alu_b_sel`=00, `alu_op`=01 (subtract), `pc_load_if_zero`=1 and `pc_src`=01 (ALU output register). All other controls are 0 in both states.
- R13: In state 9, `pc_load`=1 and `pc_src`=10 (jump target), and all other controls are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| state_o | output | 4 | Present state code |
| mem_read | output | 1 | Memory read enable |
| mem_write | output | 1 | Memory write enable |
| addr_from_alu | output | 1 | Memory address from the ALU output register (0: program counter) |
| ir_load | output | 1 | Instruction register load |
| rf_write | output | 1 | Register file write enable |
| rf_dst_rd | output | 1 | Write destination is the rd field (0: rt) |
| rf_from_mem | output | 1 | Register write data from the memory data register (0: ALU output register) |
| pc_load | output | 1 | Unconditional program counter load |
| pc_load_if_zero | output | 1 | Program counter load when the ALU zero flag is set |
| alu_a_reg | output | 1 | ALU input A from register A (0: program counter) |
| alu_b_sel | output | 2 | ALU input B source |
| alu_op | output | 2 | ALU mode to the function decoder |
| pc_src | output | 2 | Program counter source |

## Verification
The opcode is random in every cycle. Most draws are one of the five valid encodings and the rest are arbitrary 6-bit values, so every dispatch path, including both fall-backs to fetch, is taken many times. Occasional random resets in arbitrary states tell apart reset that acts at the clock edge from reset that waits for a particular state. Between clock edges the opcode is changed a second time and the controls are compared again, which shows whether any output depends on the opcode. The store opcode seen in state 1, followed by a different opcode in state 2, shows that each dispatch point samples the opcode in its own cycle.

// File: rtl/ctl_fsm_pkg.sv
package ctl_fsm_pkg;
  localparam int OPC_W   = 6;
  localparam int STATE_W = 4;

  localparam logic [STATE_W-1:0] S_FETCH   = 4'd0;
  localparam logic [STATE_W-1:0] S_DECODE  = 4'd1;
  localparam logic [STATE_W-1:0] S_MADDR   = 4'd2;
  localparam logic [STATE_W-1:0] S_MRD     = 4'd3;
  localparam logic [STATE_W-1:0] S_LDWB    = 4'd4;
  localparam logic [STATE_W-1:0] S_MWR     = 4'd5;
  localparam logic [STATE_W-1:0] S_EXEC    = 4'd6;
  localparam logic [STATE_W-1:0] S_RWB     = 4'd7;
  localparam logic [STATE_W-1:0] S_BRANCH  = 4'd8;
  localparam logic [STATE_W-1:0] S_JUMP    = 4'd9;

  typedef enum logic [2:0] {
    CLS_RTYPE, CLS_LOAD, CLS_STORE, CLS_BEQ, CLS_JUMP, CLS_OTHER
  } op_class_e;

  typedef struct packed {
    logic       mem_read;
    logic       mem_write;
    logic       addr_from_alu;
    logic       ir_load;
    logic       rf_write;
    logic       rf_dst_rd;
    logic       rf_from_mem;
    logic       pc_load;
    logic       pc_load_if_zero;
    logic       alu_a_reg;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
  } ctl_word_t;
endpackage

// File: rtl/ctl_opcode_decode.sv
module ctl_opcode_decode
  import ctl_fsm_pkg::*;
#(
  parameter logic [OPC_W-1:0] OPC_RTYPE = 6'b000000,
  parameter logic [OPC_W-1:0] OPC_LOAD  = 6'b100011,
  parameter logic [OPC_W-1:0] OPC_STORE = 6'b101011,
  parameter logic [OPC_W-1:0] OPC_BEQ   = 6'b000100,
  parameter logic [OPC_W-1:0] OPC_JUMP  = 6'b000010
) (
  input  logic [OPC_W-1:0] opcode,
  output op_class_e        op_class
);
  always_comb begin
    if      (opcode == OPC_RTYPE) op_class = CLS_RTYPE;
    else if (opcode == OPC_LOAD)  op_class = CLS_LOAD;
    else if (opcode == OPC_STORE) op_class = CLS_STORE;
    else if (opcode == OPC_BEQ)   op_class = CLS_BEQ;
    else if (opcode == OPC_JUMP)  op_class = CLS_JUMP;
    else                          op_class = CLS_OTHER;
  end
endmodule

// File: rtl/ctl_next_state.sv
module ctl_next_state
  import ctl_fsm_pkg::*;
(
  input  logic [STATE_W-1:0] state,
  input  op_class_e          op_class,
  output logic [STATE_W-1:0] state_nxt
);
  always_comb begin
    case (state)
      S_FETCH, S_MRD, S_EXEC: state_nxt = state + 1'b1;
      S_DECODE: begin
        case (op_class)
          CLS_RTYPE:           state_nxt = S_EXEC;
          CLS_LOAD, CLS_STORE: state_nxt = S_MADDR;
          CLS_BEQ:             state_nxt = S_BRANCH;
          CLS_JUMP:            state_nxt = S_JUMP;
          default:             state_nxt = S_FETCH;
        endcase
      end
      S_MADDR: begin
        case (op_class)
          CLS_LOAD:  state_nxt = S_MRD;
          CLS_STORE: state_nxt = S_MWR;
          default:   state_nxt = S_FETCH;
        endcase
      end
      default: state_nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/ctl_output_decode.sv
module ctl_output_decode
  import ctl_fsm_pkg::*;
(
  input  logic [STATE_W-1:0] state,
  output ctl_word_t          ctl
);
  always_comb begin
    ctl = '0;
    case (state)
      S_FETCH: begin
        ctl.mem_read  = 1'b1;
        ctl.ir_load   = 1'b1;
        ctl.pc_load   = 1'b1;
        ctl.alu_b_sel = 2'b01;
      end
      S_DECODE: ctl.alu_b_sel = 2'b11;
      S_MADDR: begin
        ctl.alu_a_reg = 1'b1;
        ctl.alu_b_sel = 2'b10;
      end
      S_MRD: begin
        ctl.mem_read      = 1'b1;
        ctl.addr_from_alu = 1'b1;
      end
      S_LDWB: begin
        ctl.rf_write    = 1'b1;
        ctl.rf_from_mem = 1'b1;
      end
      S_MWR: begin
        ctl.mem_write     = 1'b1;
        ctl.addr_from_alu = 1'b1;
      end
      S_EXEC: begin
        ctl.alu_a_reg = 1'b1;
        ctl.alu_op    = 2'b10;
      end
      S_RWB: begin
        ctl.rf_write  = 1'b1;
        ctl.rf_dst_rd = 1'b1;
      end
      S_BRANCH: begin
        ctl.alu_a_reg       = 1'b1;
        ctl.alu_op          = 2'b01;
        ctl.pc_load_if_zero = 1'b1;
        ctl.pc_src          = 2'b01;
      end
      S_JUMP: begin
        ctl.pc_load = 1'b1;
        ctl.pc_src  = 2'b10;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/ctl_mc_fsm.sv
module ctl_mc_fsm
  import ctl_fsm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [5:0]       opcode,
  output logic [3:0]       state_o,
  output logic             mem_read,
  output logic             mem_write,
  output logic             addr_from_alu,
  output logic             ir_load,
  output logic             rf_write,
  output logic             rf_dst_rd,
  output logic             rf_from_mem,
  output logic             pc_load,
  output logic             pc_load_if_zero,
  output logic             alu_a_reg,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_op,
  output logic [1:0]       pc_src
);
  logic [STATE_W-1:0] state_q, state_nxt;
  op_class_e          op_class;
  ctl_word_t          ctl;

  ctl_opcode_decode u_dec (.opcode(opcode), .op_class(op_class));
  ctl_next_state    u_nxt (.state(state_q), .op_class(op_class), .state_nxt(state_nxt));
  ctl_output_decode u_out (.state(state_q), .ctl(ctl));

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_FETCH;
    else     state_q <= state_nxt;
  end

  assign state_o         = state_q;
  assign mem_read        = ctl.mem_read;
  assign mem_write       = ctl.mem_write;
  assign addr_from_alu   = ctl.addr_from_alu;
  assign ir_load         = ctl.ir_load;
  assign rf_write        = ctl.rf_write;
  assign rf_dst_rd       = ctl.rf_dst_rd;
  assign rf_from_mem     = ctl.rf_from_mem;
  assign pc_load         = ctl.pc_load;
  assign pc_load_if_zero = ctl.pc_load_if_zero;
  assign alu_a_reg       = ctl.alu_a_reg;
  assign alu_b_sel       = ctl.alu_b_sel;
  assign alu_op          = ctl.alu_op;
  assign pc_src          = ctl.pc_src;

  p_reset_fetch_r1: assert property (@(posedge clk) rst |=> state_o == S_FETCH);

  p_terminal_return_r5: assert property (@(posedge clk) disable iff (rst)
    (state_o == S_LDWB || state_o == S_MWR || state_o == S_RWB ||
     state_o == S_BRANCH || state_o == S_JUMP) |=> state_o == S_FETCH);

  p_decode_jump_r3: assert property (@(posedge clk) disable iff (rst)
    (state_o == S_DECODE && opcode == 6'b000010) |=> state_o == S_JUMP);

  p_store_path_r4: assert property (@(posedge clk) disable iff (rst)
    (state_o == S_MADDR && opcode == 6'b101011) |=> state_o == S_MWR);

  p_fetch_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (state_o == S_FETCH) |=> state_o == S_DECODE);

  p_mem_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(mem_read && mem_write));

  p_one_pc_write_r12: assert property (@(posedge clk) disable iff (rst)
    $countones({pc_load, pc_load_if_zero}) <= 1);

  p_state_range_r5: assert property (@(posedge clk) disable iff (rst)
    state_o <= S_JUMP);
endmodule

// File: tb/test_ctl_mc_fsm.sv
module test_ctl_mc_fsm;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic [3:0] state_o;
  logic mem_read, mem_write, addr_from_alu, ir_load, rf_write, rf_dst_rd;
  logic rf_from_mem, pc_load, pc_load_if_zero, alu_a_reg;
  logic [1:0] alu_b_sel, alu_op, pc_src;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  ctl_mc_fsm i_ctl_mc_fsm (
    .clk(clk), .rst(rst), .opcode(opcode), .state_o(state_o),
    .mem_read(mem_read), .mem_write(mem_write), .addr_from_alu(addr_from_alu),
    .ir_load(ir_load), .rf_write(rf_write), .rf_dst_rd(rf_dst_rd),
    .rf_from_mem(rf_from_mem), .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero),
    .alu_a_reg(alu_a_reg), .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src)
  );

  function automatic logic [3:0] model_next(input logic [3:0] s, input logic [5:0] op);
    case (s)
      4'd0: return 4'd1;
      4'd1: begin
        if (op == 6'b000000) return 4'd6;
        if (op == 6'b100011 || op == 6'b101011) return 4'd2;
        if (op == 6'b000100) return 4'd8;
        if (op == 6'b000010) return 4'd9;
        return 4'd0;
      end
      4'd2: begin
        if (op == 6'b100011) return 4'd3;
        if (op == 6'b101011) return 4'd5;
        return 4'd0;
      end
      4'd3: return 4'd4;
      4'd6: return 4'd7;
      default: return 4'd0;
    endcase
  endfunction

  // bit order: mem_read mem_write addr_from_alu ir_load rf_write rf_dst_rd
  // rf_from_mem pc_load pc_load_if_zero alu_a_reg alu_b_sel alu_op pc_src
  function automatic logic [15:0] model_ctl(input logic [3:0] s);
    case (s)
      4'd0: return 16'b1001_0001_00_01_00_00;
      4'd1: return 16'b0000_0000_00_11_00_00;
      4'd2: return 16'b0000_0000_01_10_00_00;
      4'd3: return 16'b1010_0000_00_00_00_00;
      4'd4: return 16'b0000_1010_00_00_00_00;
      4'd5: return 16'b0110_0000_00_00_00_00;
      4'd6: return 16'b0000_0000_01_00_10_00;
      4'd7: return 16'b0000_1100_00_00_00_00;
      4'd8: return 16'b0000_0000_11_00_01_01;
      4'd9: return 16'b0000_0001_00_00_00_10;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string trans_tag(input logic r, input logic [3:0] s, input logic [5:0] op);
    if (r) return "R1";
    if (s == 4'd1) return (model_next(s, op) == 4'd0) ? "R6" : "R3";
    if (s == 4'd2) return "R4";
    if (s == 4'd0 || s == 4'd3 || s == 4'd6) return "R2";
    return "R5";
  endfunction

  function automatic string out_tag(input logic [3:0] s);
    case (s)
      4'd0: return "R8";
      4'd1, 4'd2: return "R9";
      4'd3, 4'd5: return "R10";
      4'd4, 4'd7: return "R11";
      4'd6, 4'd8: return "R12";
      default: return "R13";
    endcase
  endfunction

  function automatic logic [15:0] dut_ctl();
    return {mem_read, mem_write, addr_from_alu, ir_load, rf_write, rf_dst_rd,
            rf_from_mem, pc_load, pc_load_if_zero, alu_a_reg, alu_b_sel, alu_op, pc_src};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [5:0] pick_op();
    case ($urandom % 8)
      0: return 6'b000000;
      1: return 6'b100011;
      2: return 6'b101011;
      3: return 6'b000100;
      4: return 6'b000010;
      default: return 6'($urandom);
    endcase
  endfunction

  logic [3:0] model_s;
  string      pend_tag;

  task automatic step(input logic r, input logic [5:0] op);
    // called just after a falling edge: outputs of present state already checked
    opcode = op;
    rst    = r;
    #1;
    check("R7", dut_ctl(), model_ctl(model_s));
    pend_tag = trans_tag(r, model_s, op);
    model_s  = r ? 4'd0 : model_next(model_s, op);
    @(negedge clk);
    cyc++;
    check(pend_tag, {12'd0, state_o}, {12'd0, model_s});
    check(out_tag(model_s), dut_ctl(), model_ctl(model_s));
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_s = 4'd0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", {12'd0, state_o}, 16'd0);
    check("R8", dut_ctl(), model_ctl(4'd0));
    // directed: store in decode then arbitrary opcode in address state -> fetch (R4)
    step(1'b0, 6'b000000);
    step(1'b0, 6'b101011);
    step(1'b0, 6'b111111);
    // directed: unknown opcode in decode (R6)
    step(1'b0, 6'b000001);
    step(1'b0, 6'b110000);
    // directed walks through each class
    step(1'b0, 6'b000000); step(1'b0, 6'b100011); step(1'b0, 6'b100011);
    step(1'b0, 6'b000000); step(1'b0, 6'b000000);
    step(1'b0, 6'b000000); step(1'b0, 6'b000010); step(1'b0, 6'b000010);
    step(1'b0, 6'b000000); step(1'b0, 6'b000100); step(1'b0, 6'b000100);
    // reset taken in the middle of a path (R1)
    step(1'b0, 6'b000000); step(1'b0, 6'b000000); step(1'b1, 6'b000000);
    // random stream
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 40) == 0, pick_op());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule